// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Hardware Flow Control

This block moves 8-bit frames over a three-wire synchronous link: a shift clock, a data-out line and a data-in line. Each frame is shifted least-significant bit first. The outgoing bit changes on the leading edge of the shift clock, which is the edge that leaves the idle level. The incoming bit is sampled on the trailing edge, which is the edge that returns to the idle level. A polarity control chooses the idle level. The shift clock comes either from an internal programmable divider, driven out on `sclk_out`, or from the link partner on `sclk_in`. In the second case the input is synchronised into the system clock domain before its edges are detected.

Only a transmit operation produces shift clocks. To receive a frame, transmit must be enabled and a byte must be written to the transmit buffer. A dummy byte is enough, and it leaves on `txd` while the incoming frame is assembled. In continuous reception the controller writes one such byte for every frame it wants to receive. The transmit side can be held back by the partner's clear-to-send line. In external-clock mode the receive side uses request-to-send to signal that it is ready. A completed frame lands in the receive buffer, which raises a receive-complete flag and a one-cycle interrupt. If a frame completes before the previous one was read, the new frame still overwrites the buffer. In that case the overrun flag is set and no receive interrupt is raised.

Top module: `csio_xcvr`

## Requirements
- R1: In internal-clock mode, after a write with `tx_en`=1, `txd` presents the written byte least-significant bit first, one bit per leading edge of `sclk_out`. Each half period of `sclk_out` lasts `cfg_div`+1 system clocks. From the first leading edge to the eighth trailing edge there are exactly 15*(`cfg_div`+1) cycles.
- R2: The line `rxd` is sampled on each trailing edge and assembled least-significant bit first. After the eighth trailing edge `rx_data` holds the frame, `rx_done` becomes 1, and `irq_rx` pulses high for one cycle.
- R3: No shift clock runs and no frame is received while `tx_en`=0, even when the transmit buffer holds data. The frame starts once `tx_en` becomes 1.
- R4: With `cfg_cts_en`=1, a frame does not start while `cts_n` is 1. It starts after `cts_n` goes to 0.
- R5: `tbe` is 1 after reset. It goes to 0 on a write to the transmit buffer and returns to 1 when the byte moves to the shift register. `irq_tx` pulses once per such transfer.
- R6: If a frame completes while `rx_done` is 1, `ovr` becomes 1 and `rx_data` takes the new frame. No `irq_rx` pulse is raised for that frame.
- R7: A pulse on `rd_rx` clears `rx_done`. A pulse on `ovr_clr` clears `ovr` and leaves `rx_done` unchanged. Driving `rx_en` to 0 also clears `ovr`.
- R8: In external-clock mode, shifting happens only on synchronised edges of `sclk_in`. With `cfg_clk_pol`=0 the leading edge is falling. While no edge arrives, `txd` stays 1 and no frame completes. `sclk_out` holds the idle level.
- R9: In external-clock mode with `cfg_rts_en`=1 and `rx_en`=1, `rts_n` is 0 while a frame is loaded and waits for its first clock edge. It returns to 1 once the first leading edge has been seen, and it is 1 while no frame is loaded.
- R10: In internal-clock mode `rts_n` stays 1 whatever the flow-control settings.
- R11: The idle level of `sclk_out` is the inverse of `cfg_clk_pol`. With `cfg_clk_pol`=1 the clock idles low and the leading edge is rising.
- R12: After reset `txd`=1, `rts_n`=1, `tbe`=1, `rx_done`=0, `ovr`=0, and neither interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_clk | input | 1 | 1: shift clock taken from `sclk_in`; 0: internal divider |
| cfg_clk_pol | input | 1 | 0: clock idles high; 1: clock idles low |
| cfg_cts_en | input | 1 | Gate frame start on `cts_n` low |
| cfg_rts_en | input | 1 | Enable ready signalling on `rts_n` (external clock only) |
| cfg_div | input | DIV_W | Internal half period minus one, in system clocks |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wr_tx | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte written to the transmit buffer |
| rd_rx | input | 1 | Read strobe for the receive buffer |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| rx_data | output | DATA_W | Receive buffer contents |
| tbe | output | 1 | Transmit buffer empty |
| rx_done | output | 1 | Receive complete |
| ovr | output | 1 | Overrun flag |
| irq_tx | output | 1 | One-cycle transmit interrupt request |
| irq_rx | output | 1 | One-cycle receive interrupt request |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock output |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |

## Verification
The bench builds the block with its default sizes: 8-bit frames and an 8-bit divider. It sweeps the runtime divider over 2, 3, 5 and 7 and tries both clock polarities.

With `txd` looped back to `rxd`, every byte checks the transmit order and the receive assembly together. It also checks the exact frame length in cycles. A divider of 2 is the smallest that still leaves the looped-back data time to pass the input synchroniser before it is sampled.

External-clock mode is driven with a slow bench-generated `sclk_in` and an independent data pattern. This makes the request-to-send handshake and edge-only shifting observable at the ports.

// File: rtl/csio_pkg.sv
package csio_pkg;
  // one-cycle shift events derived from the shift clock
  typedef struct packed {
    logic lead;   // clock leaves its idle level: drive next bit
    logic trail;  // clock returns to idle level: sample input
  } shift_ev_t;
endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/csio_clkgen.sv
module csio_clkgen
  import csio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic             pol,
  input  logic [DIV_W-1:0] div,
  input  logic             active,
  input  logic             sclk_sync,
  output shift_ev_t        ev,
  output logic             sclk_out
);
  logic [DIV_W-1:0] cnt;
  logic             lvl;
  logic             prev;
  logic             idle_lvl;
  logic             int_tick;
  logic             ext_rise;
  logic             ext_fall;

  assign idle_lvl = ~pol;
  assign int_tick = !ext_sel && active && (cnt == div);
  assign ext_rise = sclk_sync && !prev;
  assign ext_fall = !sclk_sync && prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      lvl  <= 1'b1;
      prev <= 1'b1;
    end else begin
      prev <= sclk_sync;
      if (ext_sel || !active) begin
        cnt <= '0;
        lvl <= idle_lvl;
      end else if (cnt == div) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (ext_sel) begin
      ev.lead  = active && (pol ? ext_rise : ext_fall);
      ev.trail = active && (pol ? ext_fall : ext_rise);
    end else begin
      ev.lead  = int_tick && (lvl == idle_lvl);
      ev.trail = int_tick && (lvl != idle_lvl);
    end
  end

  assign sclk_out = lvl;
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter
  import csio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  shift_ev_t         ev,
  input  logic              rxd_s,
  output logic              busy,
  output logic              started,
  output logic              done,
  output logic [DATA_W-1:0] frame,
  output logic              txd
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      frame   <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      started <= 1'b0;
      done    <= 1'b0;
      txd     <= 1'b1;
    end else begin
      done <= 1'b0;
      if (load) begin
        tx_sh   <= load_data;
        cnt     <= '0;
        busy    <= 1'b1;
        started <= 1'b0;
      end else if (busy) begin
        if (ev.lead) begin
          txd     <= tx_sh[0];
          tx_sh   <= {1'b0, tx_sh[DATA_W-1:1]};
          started <= 1'b1;
        end
        if (ev.trail) begin
          frame <= {rxd_s, frame[DATA_W-1:1]};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
            txd  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/csio_xcvr.sv
module csio_xcvr
  import csio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ext_clk,
  input  logic              cfg_clk_pol,
  input  logic              cfg_cts_en,
  input  logic              cfg_rts_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              wr_tx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_rx,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              tbe,
  output logic              rx_done,
  output logic              ovr,
  output logic              irq_tx,
  output logic              irq_rx,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              cts_n,
  output logic              rts_n,
  input  logic              rxd,
  output logic              txd
);
  logic [2:0]        sync_q;
  logic              sclk_s, cts_s, rxd_s;
  shift_ev_t         ev;
  logic              busy, started, done;
  logic [DATA_W-1:0] frame;
  logic [DATA_W-1:0] tx_buf;
  logic              tx_full;
  logic              start;
  logic              rx_full;
  logic              ovr_q;
  logic              irq_tx_q, irq_rx_q, rts_q;

  csio_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .d({sclk_in, cts_n, rxd}), .q(sync_q)
  );
  assign {sclk_s, cts_s, rxd_s} = sync_q;

  csio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .ext_sel(cfg_ext_clk), .pol(cfg_clk_pol),
    .div(cfg_div), .active(busy), .sclk_sync(sclk_s),
    .ev(ev), .sclk_out(sclk_out)
  );

  assign start = tx_en && tx_full && !busy && (!cfg_cts_en || !cts_s);

  csio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_data(tx_buf), .ev(ev),
    .rxd_s(rxd_s), .busy(busy), .started(started), .done(done),
    .frame(frame), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf   <= '0;
      tx_full  <= 1'b0;
      rx_data  <= '0;
      rx_full  <= 1'b0;
      ovr_q    <= 1'b0;
      irq_tx_q <= 1'b0;
      irq_rx_q <= 1'b0;
      rts_q    <= 1'b1;
    end else begin
      irq_tx_q <= start;
      irq_rx_q <= 1'b0;
      // a write in the same cycle as a transfer keeps the buffer full
      if (wr_tx) begin
        tx_buf  <= wr_data;
        tx_full <= 1'b1;
      end else if (start) begin
        tx_full <= 1'b0;
      end
      if (rd_rx) rx_full <= 1'b0;
      if (!rx_en || ovr_clr) ovr_q <= 1'b0;
      if (done && rx_en) begin
        rx_data <= frame;
        if (rx_full && !rd_rx) begin
          ovr_q <= 1'b1;
        end else begin
          rx_full  <= 1'b1;
          irq_rx_q <= 1'b1;
        end
      end
      rts_q <= !(cfg_ext_clk && cfg_rts_en && rx_en && busy && !started);
    end
  end

  assign tbe     = !tx_full;
  assign rx_done = rx_full;
  assign ovr     = ovr_q;
  assign irq_tx  = irq_tx_q;
  assign irq_rx  = irq_rx_q;
  assign rts_n   = rts_q;
endmodule

// File: rtl/csio_xcvr_chk.sv
module csio_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic cfg_ext_clk,
  input logic cfg_clk_pol,
  input logic wr_tx,
  input logic tbe,
  input logic ovr,
  input logic irq_rx,
  input logic rx_done,
  input logic rts_n,
  input logic sclk_out
);
  assert_irq_rx_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    irq_rx |=> !irq_rx);

  assert_irq_sets_done_R2: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> rx_done);

  assert_tbe_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !tbe);

  assert_no_irq_on_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    (ovr && !$past(ovr)) |-> !irq_rx);

  assert_sclk_idle_ext_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_ext_clk |=> (sclk_out == !$past(cfg_clk_pol)));

  assert_rts_high_internal_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_ext_clk |=> rts_n);
endmodule

bind csio_xcvr csio_xcvr_chk u_chk (
  .clk(clk), .rst(rst), .cfg_ext_clk(cfg_ext_clk), .cfg_clk_pol(cfg_clk_pol),
  .wr_tx(wr_tx), .tbe(tbe), .ovr(ovr), .irq_rx(irq_rx), .rx_done(rx_done),
  .rts_n(rts_n), .sclk_out(sclk_out)
);

// File: tb/csio_xcvr_test.sv
module csio_xcvr_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_ext_clk = 1'b0, cfg_clk_pol = 1'b0, cfg_cts_en = 1'b0, cfg_rts_en = 1'b0;
  logic [7:0] cfg_div = 8'd2;
  logic       tx_en = 1'b0, rx_en = 1'b0, wr_tx = 1'b0, rd_rx = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rx_data;
  logic       tbe, rx_done, ovr, irq_tx, irq_rx, sclk_out, rts_n, txd;
  logic       sclk_in = 1'b1, cts_n = 1'b1, rxd_drv = 1'b1, lb = 1'b0;
  logic       rxd;
  int         tests = 0, fails = 0, n_irq_rx = 0, n_irq_tx = 0;
  bit         finished = 0;

  assign rxd = lb ? txd : rxd_drv;

  always #5 clk = ~clk;

  csio_xcvr uut (
    .clk(clk), .rst(rst), .cfg_ext_clk(cfg_ext_clk), .cfg_clk_pol(cfg_clk_pol),
    .cfg_cts_en(cfg_cts_en), .cfg_rts_en(cfg_rts_en), .cfg_div(cfg_div),
    .tx_en(tx_en), .rx_en(rx_en), .wr_tx(wr_tx), .wr_data(wr_data),
    .rd_rx(rd_rx), .ovr_clr(ovr_clr), .rx_data(rx_data), .tbe(tbe),
    .rx_done(rx_done), .ovr(ovr), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .cts_n(cts_n), .rts_n(rts_n),
    .rxd(rxd), .txd(txd)
  );

  always @(negedge clk) begin
    if (!rst && irq_rx) n_irq_rx++;
    if (!rst && irq_tx) n_irq_tx++;
  end

  // {data, divider, polarity}
  localparam logic [16:0] VEC [0:4] = '{
    {8'hA5, 8'd2, 1'b0},
    {8'h3C, 8'd3, 1'b1},
    {8'h01, 8'd5, 1'b0},
    {8'hFE, 8'd2, 1'b1},
    {8'h96, 8'd7, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] d);
    wr_tx = 1'b1; wr_data = d;
    @(negedge clk);
    wr_tx = 1'b0;
  endtask

  task automatic read_rx();
    rd_rx = 1'b1;
    @(negedge clk);
    rd_rx = 1'b0;
  endtask

  task automatic run_int_frame(input logic [7:0] d, input logic [7:0] dv, input logic p);
    logic [7:0] bits = '0;
    int nl = 0, nt = 0, cyc = 0, t_first = 0, t_last = 0, irq0, tx0;
    logic prev;
    cfg_ext_clk = 1'b0; cfg_clk_pol = p; cfg_div = dv; lb = 1'b1;
    tx_en = 1'b1; rx_en = 1'b1;
    cycles(3);
    chk(sclk_out == !p, "R11 idle level", sclk_out, !p);
    irq0 = n_irq_rx; tx0 = n_irq_tx;
    write_tx(d);
    prev = sclk_out;
    while (nt < 8 && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (sclk_out != prev) begin
        if (sclk_out != !p) begin
          bits[nl] = txd;
          if (nl == 0) t_first = cyc;
          nl++;
        end else begin
          nt++;
          t_last = cyc;
        end
        prev = sclk_out;
      end
    end
    chk(bits == d, "R1 txd bit order", bits, d);
    chk(t_last - t_first == 15 * (int'(dv) + 1), "R1 frame length", t_last - t_first, 15 * (int'(dv) + 1));
    cycles(3);
    chk(rx_done == 1'b1, "R2 rx_done set", rx_done, 1);
    chk(rx_data == d, "R2 rx_data", rx_data, d);
    chk(n_irq_rx == irq0 + 1, "R2 irq_rx once", n_irq_rx, irq0 + 1);
    chk(n_irq_tx == tx0 + 1, "R5 irq_tx once", n_irq_tx, tx0 + 1);
    chk(txd == 1'b1, "R1 txd idle after frame", txd, 1);
    read_rx();
    chk(rx_done == 1'b0, "R7 read clears rx_done", rx_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(2);
    // R12 reset state
    chk(txd == 1'b1, "R12 txd", txd, 1);
    chk(rts_n == 1'b1, "R12 rts_n", rts_n, 1);
    chk(tbe == 1'b1, "R12 tbe", tbe, 1);
    chk(rx_done == 1'b0, "R12 rx_done", rx_done, 0);
    chk(ovr == 1'b0, "R12 ovr", ovr, 0);
    chk(irq_rx == 1'b0 && irq_tx == 1'b0, "R12 irqs", {irq_rx, irq_tx}, 0);
    chk(sclk_out == 1'b1, "R11 idle high pol0", sclk_out, 1);

    // table of loopback frames: R1, R2, R11
    for (int i = 0; i < 5; i++)
      run_int_frame(VEC[i][16:9], VEC[i][8:1], VEC[i][0]);

    // R3: tx disabled holds a written byte
    cfg_clk_pol = 1'b0; cfg_div = 8'd2; tx_en = 1'b0;
    cycles(2);
    write_tx(8'h5A);
    cycles(60);
    chk(tbe == 1'b0, "R5 tbe low after write", tbe, 0);
    chk(sclk_out == 1'b1, "R3 no clock with tx_en=0", sclk_out, 1);
    chk(rx_done == 1'b0, "R3 no frame with tx_en=0", rx_done, 0);
    tx_en = 1'b1;
    cycles(80);
    chk(tbe == 1'b1, "R5 tbe back high", tbe, 1);
    chk(rx_done == 1'b1 && rx_data == 8'h5A, "R3 frame after tx_en", rx_data, 8'h5A);
    read_rx();

    // R4 CTS gating, R10 rts stays high in internal mode
    cfg_cts_en = 1'b1; cfg_rts_en = 1'b1; cts_n = 1'b1;
    write_tx(8'hC3);
    cycles(60);
    chk(tbe == 1'b0, "R4 held while cts_n high", tbe, 0);
    chk(sclk_out == 1'b1, "R4 no clock while cts_n high", sclk_out, 1);
    chk(rts_n == 1'b1, "R10 rts_n high internal", rts_n, 1);
    cts_n = 1'b0;
    cycles(80);
    chk(tbe == 1'b1, "R4 starts after cts_n low", tbe, 1);
    chk(rx_done == 1'b1 && rx_data == 8'hC3, "R4 frame received", rx_data, 8'hC3);
    read_rx();
    cfg_cts_en = 1'b0; cfg_rts_en = 1'b0; cts_n = 1'b1;

    // R6 overrun, R7 clears
    begin
      int irq0;
      irq0 = n_irq_rx;
      write_tx(8'h11); cycles(80);
      write_tx(8'h22); cycles(80);
      chk(ovr == 1'b1, "R6 ovr set", ovr, 1);
      chk(rx_data == 8'h22, "R6 new frame overwrites", rx_data, 8'h22);
      chk(n_irq_rx == irq0 + 1, "R6 no irq on overrun", n_irq_rx, irq0 + 1);
      ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
      chk(ovr == 1'b0, "R7 ovr_clr clears ovr", ovr, 0);
      chk(rx_done == 1'b1, "R7 ovr_clr keeps rx_done", rx_done, 1);
      read_rx();
      write_tx(8'h33); cycles(80);
      write_tx(8'h44); cycles(80);
      chk(ovr == 1'b1, "R6 ovr set again", ovr, 1);
      rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
      chk(ovr == 1'b0, "R7 rx_en low clears ovr", ovr, 0);
      read_rx();
    end

    // R8 / R9 external clock, polarity 0
    lb = 1'b0; rxd_drv = 1'b1; sclk_in = 1'b1;
    cfg_ext_clk = 1'b1; cfg_rts_en = 1'b1;
    cycles(5);
    chk(rts_n == 1'b1, "R9 rts_n high when nothing loaded", rts_n, 1);
    chk(sclk_out == 1'b1, "R8 sclk_out idle in ext mode", sclk_out, 1);
    write_tx(8'hA5);
    cycles(5);
    chk(rts_n == 1'b0, "R9 rts_n low when ready", rts_n, 0);
    cycles(20);
    chk(txd == 1'b1, "R8 no shift without edges", txd, 1);
    chk(rx_done == 1'b0, "R8 no frame without edges", rx_done, 0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] pat;
      pat = 8'h3C;
      sclk_in = 1'b0;
      cycles(6);
      if (i == 0) chk(rts_n == 1'b1, "R9 rts_n high after first edge", rts_n, 1);
      chk(txd == 1'(8'hA5 >> i), "R8 txd bit on falling edge", txd, 1'(8'hA5 >> i));
      rxd_drv = pat[i];
      cycles(6);
      sclk_in = 1'b1;
      cycles(6);
    end
    chk(rx_done == 1'b1 && rx_data == 8'h3C, "R8 ext frame received", rx_data, 8'h3C);
    chk(sclk_out == 1'b1, "R8 sclk_out stayed idle", sclk_out, 1);
    read_rx();

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule